// File: doc/BRIEF.md
# E3 Transmit Payload Input Interface

This block sits in front of an E3 transmit framer and turns the user's payload stream into one payload bit per bit enable. The payload arrives either one bit at a time or as 4-bit words. The bit rate comes from one of two sources. With local timing it follows a local transmit clock enable. With loop timing it follows an enable derived from the recovered receive clock. Under local timing the block is either a frame slave or a frame master. As a slave, a rising edge on an external frame reference restarts the frame. As a master, it emits a one-cycle strobe each time a new frame begins.

The block keeps the position of the current bit inside the 1536-bit E3 frame. The framer flags the overhead positions, and no payload is taken at those positions. A new mode setting is held back until the next frame boundary, so the frame in progress is always finished in the mode it started in. The whole block runs on one clock, and the two timing sources appear only as clock enables.

Top module: `e3_tx_payload_in`

## Requirements
- R1: After reset, `bit_pos` is 0 and `pay_valid`, `frame_start` and `nib_req` are low. The active mode is serial, local-timed, frame slave.
- R2: Under local timing only `loc_en` counts as a bit enable. Under loop timing only `rec_en` counts, and `loc_en` has no effect on `bit_pos` or on sampling.
- R3: Each bit enable advances `bit_pos` by one. From 1535 it wraps to 0.
- R4: In local-timed slave mode, a rising edge on `frame_ref` sets `bit_pos` to 0 in the next cycle, whatever the bit enable does. In master mode or under loop timing, `frame_ref` has no effect.
- R5: In local-timed master mode, `frame_start` is high for exactly the one cycle in which `bit_pos` has just wrapped from 1535 to 0.
- R6: Under loop timing, the master/slave setting is ignored. `frame_start` stays low and `frame_ref` is ignored, whichever way that setting is chosen.
- R7: In serial mode, the value of `ser_in` at a payload enable appears on `pay_bit` in the next cycle, with `pay_valid` high.
- R8: In nibble mode, `nib_in` is captured at the first payload enable after the word register is empty. Its bits leave MSB first (bit 3 down to bit 0), one per payload enable. The word register is emptied at every frame boundary.
- R9: In nibble mode, `nib_req` is high for one cycle after the payload enable that leaves exactly one unsent bit in the current word.
- R10: A bit enable with `ovh_flag` high consumes no payload. `pay_valid` stays low in the next cycle, and the word in progress keeps its next bit.
- R11: Changes on `cfg_nibble`, `cfg_loop` and `cfg_master` take effect only at a frame boundary, which is either a wrap of `bit_pos` or a slave reference restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_nibble | input | 1 | 1 selects 4-bit word input, 0 selects serial |
| cfg_loop | input | 1 | 1 selects loop timing (recovered enable) |
| cfg_master | input | 1 | 1 selects frame master, 0 frame slave (local timing only) |
| loc_en | input | 1 | Local transmit clock enable |
| rec_en | input | 1 | Recovered clock enable, always running |
| frame_ref | input | 1 | Frame reference, synchronous to clk |
| ovh_flag | input | 1 | Current bit position is overhead |
| ser_in | input | 1 | Serial payload input |
| nib_in | input | 4 | Nibble payload input, bit 3 sent first |
| bit_pos | output | 11 | Position in the frame, 0 to 1535 |
| frame_start | output | 1 | Master-mode frame start strobe |
| pay_bit | output | 1 | Payload bit to the framer |
| pay_valid | output | 1 | `pay_bit` holds a payload bit |
| nib_req | output | 1 | Request for the next nibble |

## Verification
A wrong position count shows at once on `bit_pos`, and it shows again when `frame_start` fails to appear at the wrap, up to 1536 enables later. A stale or too-early mode register shows within one enable as a serial bit where a nibble bit was due, or as a reference edge that is obeyed or ignored against the rule. A wrong word count in the nibble shifter shows within four payload enables, as a misplaced `nib_req` or a bit out of order. The bench therefore compares every output in every cycle against a model taken from the requirements.

// File: rtl/e3tp_pkg.sv
package e3tp_pkg;
   typedef struct packed {
      logic nibble;
      logic loop;
      logic master;
   } e3tp_mode_t;
endpackage

// File: rtl/e3tp_mode_ctl.sv
module e3tp_mode_ctl
   import e3tp_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cfg_nibble,
   input  logic       cfg_loop,
   input  logic       cfg_master,
   input  logic       boundary,
   input  logic       loc_en,
   input  logic       rec_en,
   output e3tp_mode_t mode,
   output logic       bit_en,
   output logic       ref_armed,
   output logic       gen_fs
);
   // Mode register: reloaded only at a frame boundary
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode <= '0;
      end else if (boundary) begin
         mode <= '{nibble: cfg_nibble, loop: cfg_loop, master: cfg_master};
      end
   end

   always_comb begin
      bit_en    = mode.loop ? rec_en : loc_en;
      ref_armed = !mode.loop && !mode.master;
      gen_fs    = !mode.loop && mode.master;
   end
endmodule

// File: rtl/e3tp_frame_ctr.sv
module e3tp_frame_ctr #(
   parameter int FRAME_BITS = 1536,
   localparam int PW = $clog2(FRAME_BITS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bit_en,
   input  logic          ref_armed,
   input  logic          gen_fs,
   input  logic          frame_ref,
   output logic [PW-1:0] pos,
   output logic          boundary,
   output logic          frame_start
);
   localparam logic [PW-1:0] LAST = PW'(FRAME_BITS - 1);

   if (FRAME_BITS < 8) begin : g_bad_len
      $error("e3tp_frame_ctr: FRAME_BITS too small");
   end

   logic          ref_q;
   logic          restart;
   logic          wrap;
   logic [PW-1:0] pos_inc;

   // Single-register edge detect; the reference must already be synchronous
   always_ff @(posedge clk) ref_q <= frame_ref;

   always_comb begin
      restart  = ref_armed && frame_ref && !ref_q;
      wrap     = bit_en && (pos == LAST);
      boundary = restart || wrap;
   end

   if ((FRAME_BITS & (FRAME_BITS - 1)) == 0) begin : g_pow2
      assign pos_inc = pos + PW'(1);
   end else begin : g_cmp
      assign pos_inc = (pos == LAST) ? '0 : pos + PW'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos         <= '0;
         frame_start <= 1'b0;
      end else begin
         frame_start <= wrap && gen_fs;
         if (restart)     pos <= '0;
         else if (bit_en) pos <= pos_inc;
      end
   end
endmodule

// File: rtl/e3tp_payload_path.sv
module e3tp_payload_path #(
   parameter int NIB_W = 4,
   localparam int CW = $clog2(NIB_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_en,
   input  logic             ovh_flag,
   input  logic             nibble,
   input  logic             boundary,
   input  logic             ser_in,
   input  logic [NIB_W-1:0] nib_in,
   output logic             pay_bit,
   output logic             pay_valid,
   output logic             nib_req
);
   if (NIB_W < 2) begin : g_bad_w
      $error("e3tp_payload_path: NIB_W must be at least 2");
   end

   logic [NIB_W-1:0] sh;
   logic [CW-1:0]    left;
   logic [CW-1:0]    left_after;
   logic             pen;
   logic             empty;

   always_comb begin
      pen        = bit_en && !ovh_flag;
      empty      = (left == '0);
      left_after = empty ? CW'(NIB_W - 1) : left - CW'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh        <= '0;
         left      <= '0;
         pay_bit   <= 1'b0;
         pay_valid <= 1'b0;
         nib_req   <= 1'b0;
      end else begin
         pay_valid <= pen;
         nib_req   <= pen && nibble && (left_after == CW'(1));
         if (pen) begin
            if (!nibble) begin
               pay_bit <= ser_in;
            end else if (empty) begin
               pay_bit <= nib_in[NIB_W-1];
               sh      <= {nib_in[NIB_W-2:0], 1'b0};
               left    <= left_after;
            end else begin
               pay_bit <= sh[NIB_W-1];
               sh      <= {sh[NIB_W-2:0], 1'b0};
               left    <= left_after;
            end
         end
         if (boundary) left <= '0;
      end
   end
endmodule

// File: rtl/e3_tx_payload_in.sv
module e3_tx_payload_in
   import e3tp_pkg::*;
#(
   parameter int FRAME_BITS = 1536,
   parameter int NIB_W = 4,
   localparam int PW = $clog2(FRAME_BITS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_nibble,
   input  logic             cfg_loop,
   input  logic             cfg_master,
   input  logic             loc_en,
   input  logic             rec_en,
   input  logic             frame_ref,
   input  logic             ovh_flag,
   input  logic             ser_in,
   input  logic [NIB_W-1:0] nib_in,
   output logic [PW-1:0]    bit_pos,
   output logic             frame_start,
   output logic             pay_bit,
   output logic             pay_valid,
   output logic             nib_req
);
   e3tp_mode_t mode;
   logic       bit_en;
   logic       ref_armed;
   logic       gen_fs;
   logic       boundary;

   e3tp_mode_ctl u_mode (
      .clk(clk), .rst_n(rst_n),
      .cfg_nibble(cfg_nibble), .cfg_loop(cfg_loop), .cfg_master(cfg_master),
      .boundary(boundary), .loc_en(loc_en), .rec_en(rec_en),
      .mode(mode), .bit_en(bit_en), .ref_armed(ref_armed), .gen_fs(gen_fs)
   );

   e3tp_frame_ctr #(.FRAME_BITS(FRAME_BITS)) u_ctr (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .ref_armed(ref_armed),
      .gen_fs(gen_fs), .frame_ref(frame_ref), .pos(bit_pos),
      .boundary(boundary), .frame_start(frame_start)
   );

   e3tp_payload_path #(.NIB_W(NIB_W)) u_pay (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .ovh_flag(ovh_flag),
      .nibble(mode.nibble), .boundary(boundary), .ser_in(ser_in),
      .nib_in(nib_in), .pay_bit(pay_bit), .pay_valid(pay_valid),
      .nib_req(nib_req)
   );
endmodule

// File: rtl/e3tp_checker.sv
module e3tp_checker #(
   parameter int FRAME_BITS = 1536,
   localparam int PW = $clog2(FRAME_BITS)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          frame_ref,
   input logic          ovh_flag,
   input logic          bit_en,
   input logic          boundary,
   input logic          act_nibble,
   input logic          act_loop,
   input logic          act_master,
   input logic [PW-1:0] pos,
   input logic          frame_start,
   input logic          pay_valid,
   input logic          nib_req
);
   localparam logic [PW-1:0] LAST = PW'(FRAME_BITS - 1);

   p_pos_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      pos <= LAST);

   p_pos_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_en && pos != LAST &&
       !(!act_loop && !act_master && frame_ref && !$past(frame_ref)))
      |=> pos == $past(pos) + PW'(1));

   p_ref_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!act_loop && !act_master && frame_ref && !$past(frame_ref)) |=> pos == '0);

   p_fs_at_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |-> pos == '0);

   p_fs_loop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(act_loop) |-> !frame_start);

   p_req_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
      nib_req |-> $past(act_nibble) && pay_valid);

   p_valid_ovh_r10: assert property (@(posedge clk) disable iff (!rst_n)
      pay_valid |-> $past(bit_en && !ovh_flag));

   p_mode_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !boundary |=> $stable({act_nibble, act_loop, act_master}));
endmodule

bind e3_tx_payload_in e3tp_checker #(.FRAME_BITS(FRAME_BITS)) u_chk (
   .clk(clk), .rst_n(rst_n), .frame_ref(frame_ref), .ovh_flag(ovh_flag),
   .bit_en(bit_en), .boundary(boundary), .act_nibble(mode.nibble),
   .act_loop(mode.loop), .act_master(mode.master), .pos(bit_pos),
   .frame_start(frame_start), .pay_valid(pay_valid), .nib_req(nib_req)
);

// File: tb/e3_tx_payload_in_bench.sv
module e3_tx_payload_in_bench;
   localparam int LASTP = 1535;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_nibble = 0, cfg_loop = 0, cfg_master = 0;
   logic loc_en = 0, rec_en = 0, frame_ref = 0, ovh_flag = 0, ser_in = 0;
   logic [3:0] nib_in = '0;
   logic [10:0] bit_pos;
   logic frame_start, pay_bit, pay_valid, nib_req;

   int total = 0;
   int bad = 0;

   // bench model state, built from the requirements
   int m_pos = 0;
   bit m_nib = 0, m_loop = 0, m_master = 0, m_refp = 0;
   int m_left = 0;
   bit [3:0] m_sh = '0;
   bit e_fs = 0, e_valid = 0, e_bit = 0, e_req = 0;

   always #10 clk = ~clk;

   e3_tx_payload_in u_e3_tx_payload_in (
      .clk(clk), .rst_n(rst_n), .cfg_nibble(cfg_nibble), .cfg_loop(cfg_loop),
      .cfg_master(cfg_master), .loc_en(loc_en), .rec_en(rec_en),
      .frame_ref(frame_ref), .ovh_flag(ovh_flag), .ser_in(ser_in),
      .nib_in(nib_in), .bit_pos(bit_pos), .frame_start(frame_start),
      .pay_bit(pay_bit), .pay_valid(pay_valid), .nib_req(nib_req)
   );

   task automatic chk(input bit ok, input string what, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0d exp=%0d", what, act, exp);
      end
   endtask

   // one clock: drive at negedge, model the edge, compare after it
   task automatic step(input bit l, input bit r, input bit f, input bit o,
                       input bit s, input bit [3:0] n, input string tag);
      bit en, rise, pen, bnd;
      @(negedge clk);
      loc_en = l; rec_en = r; frame_ref = f; ovh_flag = o; ser_in = s; nib_in = n;
      en   = m_loop ? r : l;
      rise = f && !m_refp && !m_loop && !m_master;
      pen  = en && !o;
      bnd  = rise || (en && m_pos == LASTP);
      e_fs = en && m_pos == LASTP && m_master && !m_loop;
      e_valid = pen;
      e_req = 0;
      if (pen) begin
         if (!m_nib) e_bit = s;
         else if (m_left == 0) begin
            e_bit = n[3]; m_sh = {n[2:0], 1'b0}; m_left = 3; e_req = 0;
         end else begin
            e_bit = m_sh[3]; m_sh = {m_sh[2:0], 1'b0}; m_left--; e_req = (m_left == 1);
         end
      end
      if (rise) m_pos = 0;
      else if (en) m_pos = (m_pos == LASTP) ? 0 : m_pos + 1;
      if (bnd) begin
         m_left = 0; m_nib = cfg_nibble; m_loop = cfg_loop; m_master = cfg_master;
      end
      m_refp = f;
      @(posedge clk); #1;
      chk(bit_pos == 11'(m_pos), {tag, " R3 bit_pos"}, bit_pos, m_pos);
      chk(frame_start == e_fs, {tag, " R5 frame_start"}, frame_start, e_fs);
      chk(pay_valid == e_valid, {tag, " R10 pay_valid"}, pay_valid, e_valid);
      chk(nib_req == e_req, {tag, " R9 nib_req"}, nib_req, e_req);
      if (e_valid) chk(pay_bit == e_bit, {tag, " R7 pay_bit"}, pay_bit, e_bit);
   endtask

   task automatic run_to_wrap(input bit l, input bit r, input string tag);
      while (m_pos != LASTP) step(l, r, 0, 0, 0, 4'h0, tag);
      step(l, r, 0, 0, 0, 4'h0, tag);
   endtask

   task automatic t_reset;
      chk(bit_pos == 0, "R1 reset bit_pos", bit_pos, 0);
      chk(!pay_valid && !frame_start && !nib_req, "R1 reset strobes",
          {pay_valid, frame_start, nib_req}, 0);
   endtask

   task automatic t_local_enables;
      for (int i = 0; i < 4; i++) step(0, 1, 0, 0, 1, 4'h0, "R2 rec ignored");
      chk(bit_pos == 0, "R2 rec_en under local", bit_pos, 0);
      for (int i = 0; i < 7; i++) step(1, 0, 0, 0, i[0], 4'h0, "R2 local");
      chk(bit_pos == 7, "R2 loc_en counted", bit_pos, 7);
   endtask

   task automatic t_ref_slave;
      step(1, 0, 1, 0, 0, 4'h0, "R4 rise");
      chk(bit_pos == 0, "R4 slave restart", bit_pos, 0);
      step(1, 0, 1, 0, 0, 4'h0, "R4 held");
      chk(bit_pos == 1, "R4 level no restart", bit_pos, 1);
      step(0, 0, 0, 0, 0, 4'h0, "R4 low");
   endtask

   task automatic t_serial;
      bit [7:0] pat = 8'b1011_0010;
      for (int i = 7; i >= 0; i--) begin
         step(1, 0, 0, 0, pat[i], 4'h0, "R7 serial");
         chk(pay_valid && pay_bit == pat[i], "R7 serial bit", pay_bit, pat[i]);
      end
      step(1, 0, 0, 1, 1, 4'h0, "R10 ovh");
      chk(!pay_valid, "R10 ovh no valid", pay_valid, 0);
   endtask

   task automatic t_nibble;
      cfg_nibble = 1;
      step(1, 0, 0, 0, 0, 4'hF, "R11 defer");
      chk(pay_bit == 0, "R11 still serial before boundary", pay_bit, 0);
      step(0, 0, 1, 0, 0, 4'h0, "R11 restart");
      step(1, 0, 0, 0, 1, 4'hA, "R8 load");
      chk(pay_bit == 1, "R8 msb first", pay_bit, 1);
      step(1, 0, 0, 0, 1, 4'h5, "R8 b2");
      chk(pay_bit == 0, "R8 bit2", pay_bit, 0);
      step(1, 0, 0, 1, 1, 4'h5, "R10 ovh in word");
      chk(!pay_valid, "R10 ovh skip", pay_valid, 0);
      step(1, 0, 0, 0, 1, 4'h5, "R8 b1");
      chk(pay_bit == 1 && nib_req, "R9 request with bit1", nib_req, 1);
      step(1, 0, 0, 0, 1, 4'h5, "R8 b0");
      chk(pay_bit == 0 && !nib_req, "R9 one-cycle request", nib_req, 0);
      for (int i = 3; i >= 0; i--) begin
         step(1, 0, 0, 0, 0, 4'h3, "R8 word2");
         chk(pay_bit == (i < 2), "R8 second word", pay_bit, i < 2);
      end
      step(1, 0, 0, 0, 0, 4'h9, "R8 partial");
      step(1, 0, 0, 0, 0, 4'h9, "R8 partial");
      cfg_nibble = 0;
      cfg_master = 1;
      step(0, 0, 0, 0, 0, 4'h0, "R8 low");
      step(0, 0, 1, 0, 0, 4'h0, "R11 to master");
   endtask

   task automatic t_master;
      int hold;
      step(1, 0, 0, 0, 0, 4'h0, "R4 master");
      step(1, 0, 0, 0, 0, 4'h0, "R4 master");
      hold = m_pos;
      step(0, 0, 1, 0, 0, 4'h0, "R4 ignored master");
      chk(bit_pos == 11'(hold), "R4 ref ignored in master", bit_pos, hold);
      step(1, 0, 0, 0, 0, 4'h0, "R4 master");
      run_to_wrap(1, 0, "R3 wrap");
      chk(frame_start && bit_pos == 0, "R5 strobe at wrap", frame_start, 1);
      step(1, 0, 0, 0, 0, 4'h0, "R5 after");
      chk(!frame_start, "R5 single cycle", frame_start, 0);
   endtask

   task automatic t_loop;
      int hold;
      cfg_loop = 1;
      run_to_wrap(1, 0, "R11 to loop");
      hold = m_pos;
      for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 0, 4'h0, "R2 loc ignored");
      chk(bit_pos == 11'(hold), "R2 loc_en ignored under loop", bit_pos, hold);
      for (int i = 0; i < 3; i++) step(0, 1, 0, 0, 1, 4'h0, "R2 rec");
      chk(bit_pos == 11'(hold + 3), "R2 rec_en counted", bit_pos, hold + 3);
      cfg_master = 0;
      step(0, 1, 1, 0, 0, 4'h0, "R6 ref ignored");
      chk(bit_pos == 11'(hold + 4), "R6 ref ignored under loop", bit_pos, hold + 4);
      run_to_wrap(0, 1, "R6 loop wrap");
      chk(!frame_start, "R6 no strobe in loop", frame_start, 0);
      step(0, 1, 0, 0, 0, 4'h0, "R6 slave setting");
      step(0, 1, 1, 0, 0, 4'h0, "R6 slave ref");
      chk(bit_pos != 0, "R6 slave ref ignored under loop", bit_pos, 2);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog R3 act=%0d exp=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      t_reset();
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_local_enables();
      t_ref_slave();
      t_serial();
      t_nibble();
      t_master();
      t_loop();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule